// File: doc/BRIEF.md
# Page-mode ROM burst reader

This block reads bursts of 16-bit words out of an asynchronous parallel mask ROM that has an 8-word page buffer. A host hands over a start word address, a burst length and a width-mode select through a valid/ready handshake. The block then walks the addresses, holds each one for a computed number of clock cycles, samples the ROM data bus and returns one word per beat with a valid strobe and a last-beat flag.

Wait states come from nanosecond figures converted to clock cycles, rounded up, from a clock-period parameter. The first access after chip enable falls, and any access whose upper address bits differ from the previous one, waits the full random-access time. Further accesses inside the open page wait only the short page time. In byte mode the ROM's top data pin serves as the least significant address bit. The block then makes two byte reads per word and packs them low byte first. When a burst ends the block raises output enable and chip enable, and it accepts no new request until the ROM's output-float time has passed.

Top module: `prom_burst_reader`

## Requirements
- R1: An access that opens a page holds its address for ceil(max(T_rand, 30 ns) / CLK_NS) cycles before the data is sampled. T_rand is 100 ns when FAST_GRADE is 1 and 120 ns when it is 0. An access inside the open page holds for ceil(30 ns / CLK_NS) cycles. With the defaults these counts are 10 and 3.
- R2: The first access of every burst waits the full page-opening time, even when it lands in the page read by the previous burst, because chip enable has been high between the bursts.
- R3: When a burst crosses from word address ...7 to ...0 (bits 2:0 roll over), the first word of the new page waits the page-opening time and later words in that page wait the page time again.
- R4: Word mode (req_byte_mode = 0) drives mem_wide high and returns the 16-bit bus value for word addresses req_addr, req_addr+1, ... in order, with the address wrapping at 2^ADDR_W.
- R5: Byte mode (req_byte_mode = 1) drives mem_wide low and mem_lsb_oe high. For each word it reads the byte at mem_lsb = 0 and then the byte at mem_lsb = 1 from mem_dq[7:0], and returns {second byte, first byte}. The second read counts as an in-page access.
- R6: A burst returns exactly req_len+1 words, each with a one-cycle rd_valid pulse, and rd_last is high only with the final word.
- R7: mem_ce_n and mem_oe_n rise on the same edge that produces the final word, and req_ready stays low for ceil(20 ns / CLK_NS) cycles after that (2 with the defaults).
- R8: While req_ready is high, mem_ce_n and mem_oe_n are both high. mem_oe_n is never low while mem_ce_n is high. req_ready is low for the whole of a burst.
- R9: After reset req_ready is 1, mem_ce_n and mem_oe_n are 1 and rd_valid is 0.
- R10: The data bus is sampled on the same clock edge on which the address changes, never after it, so that the ROM's zero output-hold time is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Number of words minus one |
| req_byte_mode | input | 1 | 1 selects byte mode, 0 selects word mode |
| rd_valid | output | 1 | Returned word is valid this cycle |
| rd_data | output | 16 | Returned word |
| rd_last | output | 1 | Final word of the burst |
| mem_addr | output | ADDR_W | ROM word address |
| mem_ce_n | output | 1 | ROM chip enable, active low |
| mem_oe_n | output | 1 | ROM output enable, active low |
| mem_wide | output | 1 | ROM width select: 1 = 16-bit, 0 = 8-bit |
| mem_lsb | output | 1 | Byte-select address bit driven on the top data pin |
| mem_lsb_oe | output | 1 | Drive enable for the top data pin |
| mem_dq | input | 16 | ROM data bus |

## Verification
The assertions check the control-pin relations on every cycle: output enable never goes low without chip enable, the bus is quiet whenever the block is ready, the release coincides with the last word, the float interval is counted out before ready returns, and byte mode always drives the address pin. Only the bench scenarios can show the wait counts themselves, the page-crossing fallback, byte packing order and address wrap. For these the bench uses a ROM model that returns corrupted data when the block samples too early, and it measures the cycle spacing between beats.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

    localparam int unsigned WORD_W    = 16;
    localparam int unsigned PAGE_BITS = 3;
    localparam int unsigned PAGE_NS   = 30;
    localparam int unsigned OE_NS     = 30;
    localparam int unsigned FLOAT_NS  = 20;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RELEASE = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              last;
        logic              valid;
    } beat_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned rand_ns(input bit fast);
        return fast ? 100 : 120;
    endfunction

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return max2(1, (ns + clk_ns - 1) / clk_ns);
    endfunction

endpackage

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // high on the edge that completes the loaded number of cycles
    assign expired = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/prom_page_track.sv
module prom_page_track #(
    parameter int unsigned PG_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            record,
    input  logic [PG_W-1:0] rec_page,
    input  logic [PG_W-1:0] query_page,
    output logic            hit
);
    logic            open_q;
    logic [PG_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            page_q <= '0;
        end else if (clear) begin
            open_q <= 1'b0;
        end else if (record) begin
            open_q <= 1'b1;
            page_q <= rec_page;
        end
    end

    assign hit = open_q && (page_q == query_page);
endmodule

// File: rtl/prom_byte_pack.sv
module prom_byte_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_low,
    input  logic [7:0]  bus_byte,
    output logic [15:0] word_o
);
    logic [7:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= '0;
        end else if (cap_low) begin
            low_q <= bus_byte;
        end
    end

    assign word_o = {bus_byte, low_q};
endmodule

// File: rtl/prom_burst_reader.sv
module prom_burst_reader
    import prom_rd_pkg::*;
#(
    parameter int unsigned CLK_NS     = 10,
    parameter bit          FAST_GRADE = 1'b1,
    parameter int unsigned ADDR_W     = 23,
    parameter int unsigned LEN_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_byte_mode,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_wide,
    output logic              mem_lsb,
    output logic              mem_lsb_oe,
    input  logic [WORD_W-1:0] mem_dq
);
    localparam int unsigned LONG_CYC  = ns_to_cyc(max2(rand_ns(FAST_GRADE), OE_NS), CLK_NS);
    localparam int unsigned SHORT_CYC = ns_to_cyc(PAGE_NS, CLK_NS);
    localparam int unsigned FLT_CYC   = ns_to_cyc(FLOAT_NS, CLK_NS);
    localparam int unsigned CNT_W     = $clog2(max2(LONG_CYC, max2(SHORT_CYC, FLT_CYC)) + 1);
    localparam int unsigned PG_W      = ADDR_W - PAGE_BITS;

    rd_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              lsb_q;
    logic              ce_n_q;
    logic              oe_n_q;
    logic              wide_q;
    logic              half_q;
    logic [LEN_W-1:0]  left_q;
    beat_t             out_q;

    logic              accept;
    logic              step;
    logic              word_done;
    logic              final_word;
    logic [ADDR_W-1:0] next_addr;
    logic              pg_hit;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [WORD_W-1:0] byte_word;
    logic [WORD_W-1:0] word_val;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign step       = (state_q == ST_ACCESS) && tmr_expired;
    assign word_done  = step && (wide_q || half_q);
    assign final_word = word_done && (left_q == '0);
    assign next_addr  = addr_q + 1'b1;
    assign word_val   = wide_q ? mem_dq : byte_word;

    // wait selection: new burst and page change pay the long wait
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(LONG_CYC);
        end else if (step) begin
            tmr_load = 1'b1;
            if (final_word) begin
                tmr_val = CNT_W'(FLT_CYC);
            end else if (!word_done) begin
                tmr_val = CNT_W'(SHORT_CYC);
            end else if (pg_hit) begin
                tmr_val = CNT_W'(SHORT_CYC);
            end else begin
                tmr_val = CNT_W'(LONG_CYC);
            end
        end
    end

    prom_wait_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    prom_page_track #(.PG_W(PG_W)) i_pages (
        .clk        (clk),
        .rst        (rst),
        .clear      (final_word),
        .record     (accept || (word_done && !final_word)),
        .rec_page   (accept ? req_addr[ADDR_W-1:PAGE_BITS] : next_addr[ADDR_W-1:PAGE_BITS]),
        .query_page (next_addr[ADDR_W-1:PAGE_BITS]),
        .hit        (pg_hit)
    );

    prom_byte_pack i_pack (
        .clk      (clk),
        .rst      (rst),
        .cap_low  (step && !wide_q && !half_q),
        .bus_byte (mem_dq[7:0]),
        .word_o   (byte_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            lsb_q   <= 1'b0;
            ce_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            wide_q  <= 1'b1;
            half_q  <= 1'b0;
            left_q  <= '0;
            out_q   <= '0;
        end else begin
            out_q.valid <= word_done;
            out_q.last  <= final_word;
            if (word_done) begin
                out_q.data <= word_val;
            end
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        lsb_q   <= 1'b0;
                        half_q  <= 1'b0;
                        ce_n_q  <= 1'b0;
                        oe_n_q  <= 1'b0;
                        wide_q  <= !req_byte_mode;
                        left_q  <= req_len;
                        state_q <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (step) begin
                        if (final_word) begin
                            ce_n_q  <= 1'b1;
                            oe_n_q  <= 1'b1;
                            state_q <= ST_RELEASE;
                        end else if (!word_done) begin
                            lsb_q  <= 1'b1;
                            half_q <= 1'b1;
                        end else begin
                            addr_q <= next_addr;
                            lsb_q  <= 1'b0;
                            half_q <= 1'b0;
                            left_q <= left_q - 1'b1;
                        end
                    end
                end
                ST_RELEASE: begin
                    if (tmr_expired) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign rd_valid   = out_q.valid;
    assign rd_last    = out_q.last;
    assign rd_data    = out_q.data;
    assign mem_addr   = addr_q;
    assign mem_ce_n   = ce_n_q;
    assign mem_oe_n   = oe_n_q;
    assign mem_wide   = wide_q;
    assign mem_lsb    = lsb_q;
    assign mem_lsb_oe = !wide_q;
endmodule

// File: rtl/prom_burst_reader_chk.sv
module prom_burst_reader_chk
    import prom_rd_pkg::*;
#(
    parameter int unsigned CLK_NS = 10
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid,
    input logic rd_last,
    input logic mem_ce_n,
    input logic mem_oe_n,
    input logic mem_wide,
    input logic mem_lsb_oe
);
    localparam int unsigned FLT_CYC = ns_to_cyc(FLOAT_NS, CLK_NS);

    // cycles spent with chip enable high, saturating
    int unsigned idle_cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cyc <= FLT_CYC;
        end else if (!mem_ce_n) begin
            idle_cyc <= 0;
        end else if (idle_cyc < FLT_CYC) begin
            idle_cyc <= idle_cyc + 1;
        end
    end

    // R8
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n);

    // R8
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_oe_n));

    // R7
    float_gap_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (idle_cyc >= FLT_CYC));

    // R7
    release_with_last_chk: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> (mem_ce_n && mem_oe_n));

    // R6
    last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid);

    // R2
    accept_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!mem_ce_n && !mem_oe_n));

    // R5
    byte_drives_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !mem_wide) |-> mem_lsb_oe);
endmodule

bind prom_burst_reader prom_burst_reader_chk #(.CLK_NS(CLK_NS)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .rd_last    (rd_last),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_wide   (mem_wide),
    .mem_lsb_oe (mem_lsb_oe)
);

// File: tb/test_prom_burst_reader.sv
module test_prom_burst_reader;
    localparam int CLK_PERIOD = 10;
    localparam int T_RAND     = 100;
    localparam int L_CYC      = ((T_RAND > 30 ? T_RAND : 30) + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int P_CYC      = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int HZ_CYC     = (20 + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [22:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        req_byte_mode = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        rd_last;
    logic [22:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_wide, mem_lsb, mem_lsb_oe;
    logic [15:0] mem_dq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prom_burst_reader i_prom_burst_reader (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_byte_mode(req_byte_mode),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_wide(mem_wide), .mem_lsb(mem_lsb), .mem_lsb_oe(mem_lsb_oe),
        .mem_dq(mem_dq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] pat(input logic [22:0] a);
        logic [15:0] m;
        m = a[15:0] * 16'h9E37;
        return m ^ {9'h0, a[22:16]} ^ 16'h5A5A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ROM model: data is corrupted until the modelled delays have elapsed
    logic [22:0] s_addr = '0;
    logic        s_lsb = 1'b0, s_wide = 1'b1, s_ce_n = 1'b1, s_oe_n = 1'b1;
    int          age_a = 0, age_o = 0, need_ns = T_RAND;
    logic        pg_open = 1'b0;
    logic [19:0] pg_q = '0;
    logic        rom_ok = 1'b0;

    always @(negedge clk) begin
        if (mem_ce_n) begin
            pg_open = 1'b0;
            age_a = 0;
        end else if (s_ce_n || mem_addr != s_addr || mem_lsb != s_lsb || mem_wide != s_wide) begin
            need_ns = (pg_open && !s_ce_n && mem_addr[22:3] == pg_q && mem_wide == s_wide) ? 30 : T_RAND;
            pg_open = 1'b1;
            pg_q = mem_addr[22:3];
            age_a = 0;
        end else begin
            age_a++;
        end
        if (mem_oe_n || s_oe_n) age_o = 0;
        else age_o++;
        s_addr = mem_addr; s_lsb = mem_lsb; s_wide = mem_wide;
        s_ce_n = mem_ce_n; s_oe_n = mem_oe_n;
        rom_ok = !mem_ce_n && !mem_oe_n && ((age_a + 1) * CLK_PERIOD >= need_ns)
                 && ((age_o + 1) * CLK_PERIOD >= 30);
    end

    always_comb begin
        logic [15:0] w;
        logic [7:0]  b;
        w = pat(mem_addr);
        b = mem_lsb ? w[15:8] : w[7:0];
        if (mem_wide) mem_dq = rom_ok ? w : ~w;
        else          mem_dq = {8'hA5, rom_ok ? b : ~b};
    end

    // scoreboard
    typedef struct {
        logic [15:0] d;
        bit          last;
        bit          first;
        int          gap;
        bit          wide;
    } exp_t;
    exp_t sb[$];
    int acc_cyc = 0;
    int ref_cyc = 0;
    bit hz_on = 0;
    int hz_cnt = 0;

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (sb.size() == 0) begin
                check(0, "R6", "unexpected beat", {16'h0, rd_data}, 32'h0);
            end else begin
                exp_t e;
                int gap;
                e = sb.pop_front();
                gap = cyc - (e.first ? acc_cyc : ref_cyc);
                ref_cyc = cyc;
                // R4 R5: data order and packing
                check(rd_data == e.d, e.wide ? "R4" : "R5", "data", {16'h0, rd_data}, {16'h0, e.d});
                // R1 R2 R3: spacing between beats
                check(gap == e.gap, e.first ? "R2" : "R3", "beat spacing", gap, e.gap);
                check(rd_last == e.last, "R6", "last flag", {31'h0, rd_last}, {31'h0, e.last});
                check(mem_wide == e.wide && mem_lsb_oe == !e.wide, "R5", "width pins",
                      {30'h0, mem_wide, mem_lsb_oe}, {30'h0, e.wide, !e.wide});
                if (e.last) begin
                    check(mem_ce_n && mem_oe_n, "R7", "release with last",
                          {30'h0, mem_ce_n, mem_oe_n}, 32'h3);
                    hz_on = 1;
                    hz_cnt = 0;
                end
            end
        end
        if (hz_on) begin
            if (!req_ready) hz_cnt++;
            else begin
                check(hz_cnt == HZ_CYC, "R7", "float interval", hz_cnt, HZ_CYC);
                hz_on = 0;
            end
        end
    end

    task automatic run_burst(input logic [22:0] a, input int len, input bit byte_mode);
        while (!req_ready) @(negedge clk);
        for (int i = 0; i <= len; i++) begin
            exp_t e;
            logic [22:0] cur, prv;
            int w;
            cur = a + 23'(i);
            prv = cur - 23'd1;
            w = (i == 0) ? L_CYC : ((cur[22:3] == prv[22:3]) ? P_CYC : L_CYC);
            e.d = pat(cur);
            e.last = (i == len);
            e.first = (i == 0);
            e.gap = byte_mode ? w + P_CYC : w;
            e.wide = !byte_mode;
            sb.push_back(e);
        end
        req_addr = a;
        req_len = 8'(len);
        req_byte_mode = byte_mode;
        req_valid = 1'b1;
        @(negedge clk);
        acc_cyc = cyc;
        req_valid = 1'b0;
        // R8: bus open, not ready during the burst
        check(!req_ready && !mem_ce_n && !mem_oe_n, "R8", "burst open",
              {29'h0, req_ready, mem_ce_n, mem_oe_n}, 32'h0);
        while (sb.size() != 0 || hz_on) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (cyc > 50000 && !finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(req_ready && mem_ce_n && mem_oe_n && !rd_valid, "R9", "reset state",
              {28'h0, req_ready, mem_ce_n, mem_oe_n, rd_valid}, 32'hE);
        run_burst(23'h000100, 7, 0);   // R1 R4: one full page
        run_burst(23'h000103, 2, 0);   // R2: same page, new burst
        run_burst(23'h000205, 9, 0);   // R3: crosses into next page
        run_burst(23'h000031, 3, 1);   // R5: byte mode within a page
        run_burst(23'h00007E, 4, 1);   // R3 R5: byte mode across a page
        run_burst(23'h000040, 0, 0);   // R6: single word
        run_burst(23'h7FFFFE, 3, 0);   // R4 R10: address wrap
        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R6", "leftover beats", sb.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule